// File: doc/BRIEF.md
# Multi-Lane Serial Video Byte Deserializer

This block turns the serial video stream of an image sensor back into bytes. The stream can use one, two or four data lines. In the wider modes the bits of a byte are interleaved across the lines: each line carries every second or every fourth bit, with the most significant bits sent first. The block runs on the serial clock. An active-high packet qualifier frames each transfer. While the qualifier is high, the block samples the enabled lines on each rising edge, builds a byte, and emits it with a one-cycle strobe and a running byte index.

The block also watches the incoming bytes of each packet for a fixed multi-byte header pattern. The pattern length and value are parameters. On the last byte of the first match in a packet it raises a header pulse. On the byte after that it raises a first-payload flag, so that downstream logic can lock onto where the packet contents begin. Dropping the qualifier ends the packet. This discards any partial byte, clears the byte index and restarts the header search.

Top module: `cam_lane_deser`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `byte_vld_o`, `hdr_found_o` and `first_payload_o` are 0, and `byte_o` and `byte_cnt_o` are 0. This holds even when reset arrives in the middle of a packet.
- R2: With `lane_mode_i` = 2'b00 (one line), `lane_i[0]` carries bits 7 down to 0 on eight consecutive sampling edges. The byte appears on `byte_o`, with `byte_vld_o` high, in the cycle after the eighth edge.
- R3: With `lane_mode_i` = 2'b01 (two lines), each byte takes four edges. On those edges `lane_i[0]` carries bits 7, 5, 3, 1 and `lane_i[1]` carries bits 6, 4, 2, 0.
- R4: With `lane_mode_i` = 2'b10 (four lines), each byte takes two edges. Line k carries bit 7-k on the first edge and bit 3-k on the second.
- R5: `lane_mode_i` = 2'b11 is handled exactly as the one-line mode.
- R6: Lines above the width of the current mode have no effect on `byte_o`.
- R7: While `frame_i` is low, no byte is produced. Any partly received byte is discarded, and the next packet starts a fresh byte.
- R8: `byte_vld_o` is high for exactly one cycle per byte. `byte_o` keeps the last byte until the next one completes.
- R9: `byte_cnt_o` gives the 1-based position of the strobed byte within the current packet. It is cleared while `frame_i` is low and saturates at all ones.
- R10: `hdr_found_o` pulses together with the strobe of a byte when that byte and the HDR_LEN-1 bytes before it, all in the same packet, equal HDR_PAT. The earliest byte is compared with the most significant byte of HDR_PAT.
- R11: `first_payload_o` pulses with the strobe of the byte right after the header. The header is detected at most once per packet, and later matches in the same packet are ignored.
- R12: `lane_mode_i` changes only while `frame_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial sampling clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Packet qualifier, high while a packet is sent |
| lane_mode_i | input | 2 | Line width: 00 one, 01 two, 10 four, 11 one |
| lane_i | input | 4 | Serial data lines |
| byte_o | output | 8 | Last rebuilt byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| byte_cnt_o | output | CNT_W | Position of the strobed byte in its packet |
| hdr_found_o | output | 1 | Header pattern completed on this byte |
| first_payload_o | output | 1 | This byte is the first one after the header |

## Verification
The bench builds the block with a three-byte header of FF A5 12 and a four-bit byte index. The short header lets the bench place a match at the start of a packet, repeat it later in the same packet, and split it across two packets. The narrow index reaches saturation within a seventeen-byte packet in four-line mode. Each line width is driven with non-zero patterns on the unused lines. Packets are also cut short mid-byte, and reset is applied in the middle of a packet.

// File: rtl/cdes_pkg.sv
package cdes_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned MAX_LANES = 4;
    localparam int unsigned PH_W      = 3;

    typedef enum logic [1:0] {
        LM_X1  = 2'b00,
        LM_X2  = 2'b01,
        LM_X4  = 2'b10,
        LM_RSV = 2'b11
    } lane_mode_e;

    typedef enum logic [1:0] {
        HS_SEEK   = 2'b00,
        HS_ARMED  = 2'b01,
        HS_LOCKED = 2'b10
    } hdr_state_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } byte_beat_t;

    // Sampling edges needed to complete one byte in a given mode.
    function automatic logic [3:0] beats_of(lane_mode_e m);
        case (m)
            LM_X2:   return 4'd4;
            LM_X4:   return 4'd2;
            default: return 4'd8;
        endcase
    endfunction

    // Append the bits of one edge below the bits already held; line 0 is the
    // more significant of the newly added bits.
    function automatic logic [BYTE_W-1:0] shift_in(logic [BYTE_W-2:0] acc,
                                                   logic [MAX_LANES-1:0] l,
                                                   lane_mode_e m);
        case (m)
            LM_X2:   return {acc[5:0], l[0], l[1]};
            LM_X4:   return {acc[3:0], l[0], l[1], l[2], l[3]};
            default: return {acc[6:0], l[0]};
        endcase
    endfunction

endpackage

// File: rtl/cdes_lane_shift.sv
module cdes_lane_shift
    import cdes_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_i,
    input  lane_mode_e           mode_i,
    input  logic [MAX_LANES-1:0] lane_i,
    output byte_beat_t           beat_o
);

    logic [BYTE_W-2:0] acc_q;
    logic [PH_W-1:0]   ph_q;
    logic [BYTE_W-1:0] shifted;
    logic              last_beat;

    always_comb begin
        shifted   = shift_in(acc_q, lane_i, mode_i);
        last_beat = ({1'b0, ph_q} == (beats_of(mode_i) - 4'd1));
        beat_o.vld  = frame_i && last_beat;
        beat_o.data = shifted;
    end

    always_ff @(posedge clk) begin
        if (rst || !frame_i) begin
            acc_q <= '0;
            ph_q  <= '0;
        end else begin
            acc_q <= shifted[BYTE_W-2:0];
            ph_q  <= last_beat ? '0 : ph_q + 1'b1;
        end
    end

    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (frame_i && $past(frame_i)) |-> $stable(mode_i)); // R12

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        frame_i |-> ({1'b0, ph_q} < beats_of(mode_i))); // R12

endmodule

// File: rtl/cdes_byte_count.sv
module cdes_byte_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_i,
    input  logic             beat_vld_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || !frame_i) begin
            cnt_o <= '0;
        end else if (beat_vld_i && (cnt_o != CNT_MAX)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (frame_i && beat_vld_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R9

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frame_i && !beat_vld_i) |=> $stable(cnt_o)); // R9

endmodule

// File: rtl/cdes_hdr_match.sv
module cdes_hdr_match
    import cdes_pkg::*;
#(
    parameter int unsigned HDR_LEN = 4,
    parameter logic [HDR_LEN*BYTE_W-1:0] HDR_PAT = 32'hFF00_FF00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_i,
    input  byte_beat_t beat_i,
    output logic       hdr_found_o,
    output logic       first_o
);

    localparam int unsigned WIN_W = HDR_LEN * BYTE_W;

    logic [WIN_W-1:0] window;
    logic             primed;
    logic             hit;
    hdr_state_e       state_q;

    generate
        if (HDR_LEN > 1) begin : g_hist
            localparam int unsigned HIST_W = WIN_W - BYTE_W;
            localparam int unsigned FILL_W = $clog2(HDR_LEN);
            localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HDR_LEN - 1);

            logic [HIST_W-1:0] hist_q;
            logic [FILL_W-1:0] fill_q;

            assign window = {hist_q, beat_i.data};
            assign primed = (fill_q == FILL_FULL);

            always_ff @(posedge clk) begin
                if (rst || !frame_i) begin
                    hist_q <= '0;
                    fill_q <= '0;
                end else if (beat_i.vld) begin
                    hist_q <= window[HIST_W-1:0];
                    if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
                end
            end
        end else begin : g_single
            assign window = beat_i.data;
            assign primed = 1'b1;
        end
    endgenerate

    assign hit = beat_i.vld && (state_q == HS_SEEK) && primed && (window == HDR_PAT);

    always_ff @(posedge clk) begin
        if (rst || !frame_i) begin
            state_q     <= HS_SEEK;
            hdr_found_o <= 1'b0;
            first_o     <= 1'b0;
        end else begin
            hdr_found_o <= hit;
            first_o     <= beat_i.vld && (state_q == HS_ARMED);
            if (beat_i.vld) begin
                case (state_q)
                    HS_SEEK:  if (hit) state_q <= HS_ARMED;
                    HS_ARMED: state_q <= HS_LOCKED;
                    default:  state_q <= state_q;
                endcase
            end
        end
    end

    AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == HS_LOCKED && frame_i) |=> !hdr_found_o); // R11

    AST_ARM_AFTER_HIT: assert property (@(posedge clk) disable iff (rst)
        hdr_found_o |-> (state_q == HS_ARMED)); // R11

endmodule

// File: rtl/cam_lane_deser.sv
module cam_lane_deser
    import cdes_pkg::*;
#(
    parameter int unsigned HDR_LEN = 4,
    parameter logic [HDR_LEN*8-1:0] HDR_PAT = 32'hFF00_FF00,
    parameter int unsigned CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_i,
    input  logic [1:0]       lane_mode_i,
    input  logic [3:0]       lane_i,
    output logic [7:0]       byte_o,
    output logic             byte_vld_o,
    output logic [CNT_W-1:0] byte_cnt_o,
    output logic             hdr_found_o,
    output logic             first_payload_o
);

    byte_beat_t beat;
    lane_mode_e mode;

    assign mode = lane_mode_e'(lane_mode_i);

    cdes_lane_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame_i),
        .mode_i  (mode),
        .lane_i  (lane_i),
        .beat_o  (beat)
    );

    cdes_byte_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .frame_i    (frame_i),
        .beat_vld_i (beat.vld),
        .cnt_o      (byte_cnt_o)
    );

    cdes_hdr_match #(.HDR_LEN(HDR_LEN), .HDR_PAT(HDR_PAT)) u_match (
        .clk         (clk),
        .rst         (rst),
        .frame_i     (frame_i),
        .beat_i      (beat),
        .hdr_found_o (hdr_found_o),
        .first_o     (first_payload_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_o     <= '0;
            byte_vld_o <= 1'b0;
        end else begin
            byte_vld_o <= beat.vld;
            if (beat.vld) byte_o <= beat.data;
        end
    end

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |=> !byte_vld_o); // R8

    AST_VLD_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> $past(frame_i)); // R7

    AST_HDR_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
        hdr_found_o |-> byte_vld_o); // R10

    AST_FIRST_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
        first_payload_o |-> (byte_vld_o && !hdr_found_o)); // R11

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> (byte_cnt_o != '0)); // R9

endmodule

// File: tb/sim_cam_lane_deser.sv
`timescale 1ns/1ps
module sim_cam_lane_deser;

    localparam int unsigned HDR_LEN = 3;
    localparam logic [23:0] HDR_PAT = 24'hFFA512;
    localparam int unsigned CNT_W   = 4;
    localparam int unsigned NV      = 12;

    // {mode[1:0], byte[7:0], unused-line junk[3:0]}
    localparam logic [13:0] VEC [NV] = '{
        {2'b00, 8'hA5, 4'hE}, {2'b00, 8'h3C, 4'h0}, {2'b00, 8'h80, 4'hA},
        {2'b00, 8'h01, 4'hF}, {2'b01, 8'h96, 4'hC}, {2'b01, 8'hE1, 4'h4},
        {2'b01, 8'h0F, 4'hF}, {2'b10, 8'h5A, 4'h0}, {2'b10, 8'hC3, 4'h0},
        {2'b10, 8'h7E, 4'h0}, {2'b11, 8'h4D, 4'hE}, {2'b11, 8'hB2, 4'h6}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             frame_i = 1'b0;
    logic [1:0]       lane_mode_i = 2'b00;
    logic [3:0]       lane_i = 4'h0;
    logic [7:0]       byte_o;
    logic             byte_vld_o;
    logic [CNT_W-1:0] byte_cnt_o;
    logic             hdr_found_o;
    logic             first_payload_o;

    int tests = 0;
    int fails = 0;

    logic [7:0]       cd [64];
    logic [CNT_W-1:0] cc [64];
    logic             ch [64];
    logic             cf [64];
    int               cap_n = 0;

    always #4 clk = ~clk;

    cam_lane_deser #(.HDR_LEN(HDR_LEN), .HDR_PAT(HDR_PAT), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .frame_i(frame_i), .lane_mode_i(lane_mode_i),
        .lane_i(lane_i), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
        .byte_cnt_o(byte_cnt_o), .hdr_found_o(hdr_found_o),
        .first_payload_o(first_payload_o)
    );

    always @(negedge clk) begin
        if (!rst && byte_vld_o && cap_n < 64) begin
            cd[cap_n] = byte_o;
            cc[cap_n] = byte_cnt_o;
            ch[cap_n] = hdr_found_o;
            cf[cap_n] = first_payload_o;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [1:0] m, input logic [7:0] b,
                             input logic [3:0] junk);
        int w;
        w = (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
        for (int c = 0; c < 8 / w; c++) begin
            @(negedge clk);
            frame_i     = 1'b1;
            lane_mode_i = m;
            for (int j = 0; j < 4; j++)
                lane_i[j] = (j < w) ? b[7 - c * w - j] : (junk[j] ^ c[0]);
        end
    endtask

    task automatic end_packet();
        @(negedge clk);
        frame_i = 1'b0;
        lane_i  = 4'h0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        logic [7:0] hp [8];
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", byte_vld_o, 0, "vld in reset");
        chk("R1", byte_cnt_o, 0, "cnt in reset");
        chk("R1", {hdr_found_o, first_payload_o}, 0, "flags in reset");
        chk("R1", byte_o, 0, "byte in reset");
        rst = 1'b0;
        @(negedge clk);
        chk("R1", byte_vld_o, 0, "vld after reset");

        // Table walk: one single-byte packet per vector
        for (int i = 0; i < NV; i++) begin
            logic [1:0] m;
            m = VEC[i][13:12];
            base = cap_n;
            send_byte(m, VEC[i][11:4], VEC[i][3:0]);
            end_packet();
            chk(m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R4" : "R5",
                cap_n - base, 1, "byte count of packet");
            chk(m == 0 ? "R2 R6" : m == 1 ? "R3 R6" : m == 2 ? "R4 R6" : "R5 R6",
                cd[base], VEC[i][11:4], "rebuilt byte");
            chk("R9", cc[base], 1, "index of single byte");
        end

        // R7: cut a byte short, idle with lines toggling, then a clean byte
        base = cap_n;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            frame_i = 1'b1;
            lane_mode_i = 2'b00;
            lane_i = 4'hF;
        end
        @(negedge clk);
        frame_i = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            lane_i = k[3:0];
        end
        chk("R7", cap_n - base, 0, "bytes with frame low");
        send_byte(2'b00, 8'h3C, 4'h0);
        end_packet();
        chk("R7", cap_n - base, 1, "bytes after restart");
        chk("R7", cd[base], 8'h3C, "byte after restart");
        chk("R9", cc[base], 1, "index after restart");

        // R10/R11: header inside a two-line packet, repeated later
        hp = '{8'h11, 8'hFF, 8'hA5, 8'h12, 8'h77, 8'hFF, 8'hA5, 8'h12};
        base = cap_n;
        for (int k = 0; k < 8; k++) send_byte(2'b01, hp[k], 4'h0);
        end_packet();
        chk("R8", cap_n - base, 8, "strobes in header packet");
        for (int k = 0; k < 8; k++) begin
            chk("R9", cc[base + k], k + 1, "byte index");
            chk("R10", ch[base + k], (k == 3), "header pulse");
            chk("R11", cf[base + k], (k == 4), "first payload flag");
            chk("R3", cd[base + k], hp[k], "header packet byte");
        end
        repeat (5) @(negedge clk);
        chk("R8", byte_o, 8'h12, "byte held when idle");
        chk("R8", byte_vld_o, 0, "no strobe when idle");

        // R10: header split across two packets must not match
        base = cap_n;
        send_byte(2'b10, 8'hFF, 4'h0);
        send_byte(2'b10, 8'hA5, 4'h0);
        end_packet();
        send_byte(2'b10, 8'h12, 4'h0);
        send_byte(2'b10, 8'h55, 4'h0);
        end_packet();
        chk("R10", ch[base] | ch[base+1] | ch[base+2] | ch[base+3], 0, "split header");
        chk("R11", cf[base+3], 0, "no payload flag after split");
        chk("R9", cc[base + 2], 1, "index restarts per packet");

        // R10/R11: header at packet start in four-line mode
        base = cap_n;
        send_byte(2'b10, 8'hFF, 4'h0);
        send_byte(2'b10, 8'hA5, 4'h0);
        send_byte(2'b10, 8'h12, 4'h0);
        send_byte(2'b10, 8'h9C, 4'h0);
        end_packet();
        chk("R10", ch[base + 2], 1, "header at start");
        chk("R11", cf[base + 3], 1, "payload flag at start");
        chk("R4", cd[base + 3], 8'h9C, "payload byte");

        // R9: saturation of the index
        base = cap_n;
        for (int k = 0; k < 17; k++) send_byte(2'b10, k[7:0] + 8'h20, 4'h0);
        end_packet();
        chk("R9", cc[base + 14], 15, "index at 15th byte");
        chk("R9", cc[base + 16], 15, "index saturated");
        chk("R4", cd[base + 16], 8'h30, "last byte of long packet");

        // R1: reset in the middle of a packet
        send_byte(2'b00, 8'hAA, 4'h0);
        send_byte(2'b00, 8'h55, 4'h0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", {byte_vld_o, hdr_found_o, first_payload_o}, 0, "flags after mid reset");
        chk("R1", byte_cnt_o, 0, "cnt after mid reset");
        chk("R1", byte_o, 0, "byte after mid reset");
        frame_i = 1'b0;
        rst = 1'b0;
        repeat (2) @(negedge clk);

        summary();
        $finish;
    end

endmodule